// File: doc/BRIEF.md
# Baud Strobe Generator

This block makes the two timing enables that a serial receiver and transmitter need. Both are one-cycle pulses in the peripheral clock domain. A 2-bit source select picks what feeds the divider. The choices are every peripheral clock cycle, one cycle in eight from a free-running prescaler, or the rising edges of an external serial clock. A programmable 16-bit divisor turns those source ticks into the sampling strobe. A second counter turns groups of 8 or 16 sampling strobes into the bit-rate strobe, and the oversampling bit picks the group size.

The divider is a small state machine whose state follows the divisor:

- `DIV_HALT` applies when the divisor is 0. No strobes are produced.
- `DIV_PASS` applies when the divisor is 1. Every source tick becomes a sampling strobe.
- `DIV_COUNT` applies to any larger divisor. The divider counts source ticks.

The transitions `halt_to_pass`, `halt_to_count`, `pass_to_halt`, `pass_to_count`, `count_to_halt` and `count_to_pass` are taken on the clock edge after the divisor input moves into another class. A change to any configuration input restarts both counters, so the first period after a change already has the new length.

Top module: `baud_strobe_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `samp_en` and `bit_en` are low.
- R2: With `src_sel` = 0 (every peripheral cycle) and divisor N >= 2, consecutive `samp_en` pulses are exactly N cycles apart.
- R3: With divisor 1 the divider is bypassed. With `src_sel` = 0, `samp_en` is high on every cycle.
- R4: With divisor 0, neither `samp_en` nor `bit_en` ever pulses.
- R5: With `src_sel` = 1 (prescaler, one tick every 8 peripheral cycles) and divisor N, `samp_en` pulses are 8*N cycles apart.
- R6: With `src_sel` = 3 (external clock), each synchronized rising edge of `ext_clk` is one source tick. If `ext_clk` has a period of P cycles, `samp_en` pulses are P*N cycles apart.
- R7: `src_sel` = 2 is reserved and gives no source ticks, so `samp_en` stays low.
- R8: With `over8` = 0, `bit_en` pulses are 16 sampling periods apart. With `over8` = 1, they are 8 sampling periods apart.
- R9: `bit_en` is high only in a cycle where `samp_en` is also high. Both pulses are one cycle wide.
- R10: A change of `src_sel`, `divisor` or `over8` restarts both counters. With `src_sel` = 0, the change is driven before clock edge 1, and the new divisor is N >= 2. The first `samp_en` is then seen after edge N+1, and the first `bit_en` is seen after edge 8N+1 (`over8` = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Source: 0 every cycle, 1 prescaled by 8, 2 reserved, 3 external clock |
| divisor | input | 16 | Source ticks per sampling strobe; 0 stops, 1 bypasses |
| over8 | input | 1 | 1: 8 samples per bit; 0: 16 samples per bit |
| ext_clk | input | 1 | External serial clock, asynchronous |
| samp_en | output | 1 | One-cycle sampling strobe |
| bit_en | output | 1 | One-cycle bit-rate strobe |

## Verification
The assertions assume that `ext_clk` has high and low phases longer than one peripheral cycle and a period of at least three cycles. They also assume that the configuration inputs change only on a clock boundary. The bench drives every input at the falling edge. Its external clock runs with half periods of two to four cycles. Random configurations draw their source only from codes 0, 1 and 3 and their divisor from 2 to 6. The reserved code and divisors 0 and 1 are tried in directed cases.

// File: rtl/baud_strobe_pkg.sv
package baud_strobe_pkg;
    typedef enum logic [1:0] {
        SRC_CORE = 2'd0,
        SRC_PRE8 = 2'd1,
        SRC_RSVD = 2'd2,
        SRC_EXT  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        DIV_HALT  = 2'd0,
        DIV_PASS  = 2'd1,
        DIV_COUNT = 2'd2
    } div_state_e;
endpackage

// File: rtl/bsg_src_tick.sv
module bsg_src_tick #(
    parameter int PRE_DIV   = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       ext_clk,
    output logic       src_tick
);
    import baud_strobe_pkg::*;
    localparam int PW = $clog2(PRE_DIV);

    logic [PW-1:0]         pre_cnt;
    logic [SYNC_DEPTH:0]   sync_q;
    logic                  pre_tick;
    logic                  ext_tick;

    always_ff @(posedge clk) begin
        if (!rst_n) pre_cnt <= '0;
        else if (pre_cnt == PW'(PRE_DIV - 1)) pre_cnt <= '0;
        else pre_cnt <= pre_cnt + 1'b1;
    end
    assign pre_tick = (pre_cnt == PW'(PRE_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else sync_q <= {sync_q[SYNC_DEPTH-1:0], ext_clk};
    end
    assign ext_tick = sync_q[SYNC_DEPTH-1] & ~sync_q[SYNC_DEPTH];

    always_comb begin
        unique case (src_e'(src_sel))
            SRC_CORE: src_tick = 1'b1;
            SRC_PRE8: src_tick = pre_tick;
            SRC_RSVD: src_tick = 1'b0;
            SRC_EXT:  src_tick = ext_tick;
            default:  src_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/bsg_divider.sv
module bsg_divider #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] divisor,
    input  logic          reload,
    input  logic          src_tick,
    output logic          samp_next
);
    import baud_strobe_pkg::*;

    div_state_e    state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic          wrap;

    always_comb begin
        if (divisor == '0)              state_d = DIV_HALT;
        else if (divisor == DW'(1))     state_d = DIV_PASS;
        else                            state_d = DIV_COUNT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DIV_HALT;
        else        state_q <= state_d;
    end

    assign wrap = (cnt_q == divisor - DW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || reload) cnt_q <= '0;
        else if (state_q == DIV_COUNT && src_tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        else if (state_q != DIV_COUNT) cnt_q <= '0;
    end

    // outputs
    always_comb begin
        samp_next = 1'b0;
        if (!reload) begin
            unique case (state_q)
                DIV_HALT:  samp_next = 1'b0;
                DIV_PASS:  samp_next = src_tick;
                DIV_COUNT: samp_next = src_tick & wrap;
                default:   samp_next = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/bsg_oversample.sv
module bsg_oversample #(
    parameter int LO_RATIO = 8,
    parameter int HI_RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic over8,
    input  logic reload,
    input  logic samp_next,
    output logic bit_next
);
    localparam int OW = $clog2(HI_RATIO);

    logic [OW-1:0] os_q;
    logic [OW-1:0] last;

    assign last     = over8 ? OW'(LO_RATIO - 1) : OW'(HI_RATIO - 1);
    assign bit_next = samp_next & (os_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n || reload) os_q <= '0;
        else if (samp_next)   os_q <= (os_q == last) ? '0 : os_q + 1'b1;
    end
endmodule

// File: rtl/baud_strobe_gen.sv
module baud_strobe_gen #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    src_sel,
    input  logic [DW-1:0] divisor,
    input  logic          over8,
    input  logic          ext_clk,
    output logic          samp_en,
    output logic          bit_en
);
    localparam int CW = DW + 3;

    logic [CW-1:0] cfg_q;
    logic [CW-1:0] cfg_now;
    logic          reload;
    logic          src_tick;
    logic          samp_next;
    logic          bit_next;

    assign cfg_now = {src_sel, divisor, over8};
    assign reload  = (cfg_now != cfg_q);

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_now;
    end

    bsg_src_tick #(.PRE_DIV(8), .SYNC_DEPTH(2)) u_src (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .ext_clk(ext_clk), .src_tick(src_tick)
    );

    bsg_divider #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .reload(reload),
        .src_tick(src_tick), .samp_next(samp_next)
    );

    bsg_oversample #(.LO_RATIO(8), .HI_RATIO(16)) u_os (
        .clk(clk), .rst_n(rst_n), .over8(over8), .reload(reload),
        .samp_next(samp_next), .bit_next(bit_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_en <= 1'b0;
            bit_en  <= 1'b0;
        end else begin
            samp_en <= samp_next;
            bit_en  <= bit_next;
        end
    end
endmodule

// File: rtl/baud_strobe_chk.sv
module baud_strobe_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    src_sel,
    input logic [DW-1:0] divisor,
    input logic          over8,
    input logic          samp_en,
    input logic          bit_en
);
    // R9
    bit_in_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> samp_en);

    // R4
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(divisor) == '0) |-> (!samp_en && !bit_en));

    // R7
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_sel) == 2'd2) |-> !samp_en);

    // R10
    reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && ($past(divisor) != $past(divisor, 2))) |-> !samp_en);

    // R3
    bypass_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(src_sel) == 2'd0 && $past(src_sel, 2) == 2'd0
         && $past(divisor) == DW'(1) && $past(divisor, 2) == DW'(1)
         && $past(over8) == $past(over8, 2)) |-> samp_en);
endmodule

bind baud_strobe_gen baud_strobe_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .divisor(divisor),
    .over8(over8), .samp_en(samp_en), .bit_en(bit_en)
);

// File: tb/sim_baud_strobe_gen.sv
module sim_baud_strobe_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'd0;
    logic [15:0] divisor = 16'd0;
    logic        over8 = 1'b0;
    logic        ext_clk = 1'b0;
    logic        samp_en, bit_en;
    int          ext_half = 0;
    int          checks = 0;
    int          errors = 0;
    int          cyc_total = 0;

    always #10 clk = ~clk;

    baud_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .divisor(divisor),
        .over8(over8), .ext_clk(ext_clk), .samp_en(samp_en), .bit_en(bit_en)
    );

    initial begin
        forever begin
            if (ext_half == 0) begin
                ext_clk = 1'b0;
                @(negedge clk);
            end else begin
                repeat (ext_half) @(negedge clk);
                ext_clk = ~ext_clk;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            cyc_total++;
            if (cyc_total > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_total);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    function automatic int exp_samp_gap(input int src, input int n, input int half);
        if (src == 0) return n;
        if (src == 1) return 8 * n;
        return 2 * half * n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // cycles between two consecutive pulses of samp (sel=0) or bit (sel=1)
    task automatic gap(input int sel, output int g);
        int k = 0;
        g = -1;
        while (((sel == 0) ? samp_en : bit_en) !== 1'b1 && k < 20000) begin
            @(negedge clk); k++;
        end
        if (k >= 20000) return;
        @(negedge clk); k = 1;
        while (((sel == 0) ? samp_en : bit_en) !== 1'b1 && k < 20000) begin
            @(negedge clk); k++;
        end
        if (k < 20000) g = k;
    endtask

    task automatic count_window(input int n, output int s, output int b, output int bad);
        s = 0; b = 0; bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (samp_en) s++;
            if (bit_en) b++;
            if (bit_en && !samp_en) bad++;
        end
    endtask

    task automatic setcfg(input int src, input int n, input bit ov, input int half);
        @(negedge clk);
        src_sel = 2'(src); divisor = 16'(n); over8 = ov; ext_half = half;
        repeat (4 * half + 3) @(negedge clk);
    endtask

    initial begin
        int g, s, b, bad, k;
        repeat (4) @(negedge clk);
        check("R1 samp in reset", int'(samp_en), 0);
        check("R1 bit in reset", int'(bit_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 samp after reset", int'(samp_en), 0);
        check("R1 bit after reset", int'(bit_en), 0);

        setcfg(0, 5, 1'b0, 0);
        gap(0, g); check("R2 samp gap N=5", g, 5);
        gap(1, g); check("R8 bit gap over16", g, 80);

        setcfg(0, 1, 1'b1, 0);
        count_window(40, s, b, bad);
        check("R3 bypass strobes", s, 40);
        check("R8 bit count over8 bypass", b, 5);
        check("R9 bit without samp", bad, 0);

        setcfg(0, 0, 1'b1, 0);
        count_window(200, s, b, bad);
        check("R4 samp with div 0", s, 0);
        check("R4 bit with div 0", b, 0);

        setcfg(1, 3, 1'b1, 0);
        gap(0, g); check("R5 prescaled gap", g, 24);
        gap(1, g); check("R8 bit gap over8", g, 192);

        setcfg(3, 2, 1'b0, 3);
        gap(0, g); check("R6 external gap", g, 12);

        setcfg(2, 4, 1'b0, 0);
        count_window(300, s, b, bad);
        check("R7 reserved samp", s, 0);

        // R10 restart timing
        setcfg(0, 5, 1'b1, 0);
        repeat (2) @(negedge clk);
        divisor = 16'd3;
        k = 0; g = -1;
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            if (samp_en && g < 0) g = i;
            if (bit_en) begin k = i; break; end
        end
        check("R10 first samp delay", g, 4);
        check("R10 first bit delay", k, 25);

        for (int t = 0; t < 10; t++) begin
            int src, n, h;
            bit ov;
            src = ($urandom % 3 == 0) ? 0 : (($urandom % 2 == 0) ? 1 : 3);
            n = 2 + $urandom % 5;
            h = 2 + $urandom % 3;
            ov = 1'($urandom % 2);
            setcfg(src, n, ov, (src == 3) ? h : 0);
            gap(0, g);
            check((src == 0) ? "R2 random samp gap" : (src == 1) ? "R5 random samp gap"
                  : "R6 random samp gap", g, exp_samp_gap(src, n, h));
            gap(1, g);
            check("R8 random bit gap", g, exp_samp_gap(src, n, h) * (ov ? 8 : 16));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial void'($urandom(32'd1234));
endmodule